// File: doc/BRIEF.md
# Character LCD 4-bit interface controller

This block drives a two-line, sixteen-column character display through a four-bit data bus. When reset is released it brings the display up by itself. It first waits for the display to power up. It then sends four single nibbles, which switch the display into four-bit mode, and four configuration bytes. Only after that does it offer a request port to the rest of the chip.

Each request is one of three kinds: an instruction byte, a data byte, or a cursor move given as a line and a column. Every byte leaves as two nibbles, upper nibble first, and each nibble is strobed by an enable pulse. All waits the display needs are derived from the `CLK_HZ` parameter. A separate drive-enable output marks the interval in which the controller owns the shared data pins. Outside that interval the bus is parked at zero.

Top module: `lcd_nibble_ctrl`

## Requirements
- R1: While reset is held, `lcd_e`, `lcd_rs`, `lcd_rw`, `lcd_drive` and `lcd_db` are 0 and `req_ready` is 0.
- R2: The first enable pulse after reset release rises more than 15 ms after the release.
- R3: The power-up sequence begins with four single nibbles, 0x3, 0x3, 0x3 and 0x2, all with RS=0. The gaps from the fall of each enable to the rise of the next exceed 4.1 ms, 100 µs, 40 µs and 40 µs respectively.
- R4: The power-up sequence continues with the bytes 0x28, 0x06, 0x0C and 0x01, in that order, as instructions. `req_ready` first rises only after that sequence has ended.
- R5: Every byte goes out as its upper nibble, then a gap of more than 1 µs, then its lower nibble. The trailing wait after the lower nibble exceeds 40 µs, except as R9 states. `req_ready` stays 0 until the trailing wait has ended.
- R6: `lcd_rs` is 0 for instruction and cursor transfers and 1 for data transfers. `lcd_rw` is always 0.
- R7: RS and the data nibble are steady at least 40 ns before the enable rises and stay steady while it is high. Each enable pulse is high for more than 230 ns.
- R8: A cursor request sends the instruction byte 0x80 + column for line 0 (`req_line`=0) and 0xC0 + column for line 1 (`req_line`=1). The column is 0 to 15.
- R9: After the instruction byte 0x01 (clear), whether sent during power-up or on request, the trailing wait exceeds 1.64 ms before `req_ready` returns.
- R10: `lcd_drive` is 1 whenever the enable is high. It stays 1 until the trailing wait of a transfer has ended. Whenever it is 0, `lcd_e`, `lcd_rs` and `lcd_db` are 0.
- R11: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1, and `req_ready` is 0 while the bus is driven. `req_kind` is decoded as follows: bit 1 = 1 selects a cursor move (`req_byte` is ignored). Otherwise bit 0 selects data (1) or an instruction (0), and `req_line` and `req_col` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at `CLK_HZ` |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_kind | input | 2 | Request kind: 1x cursor, 01 data, 00 instruction |
| req_byte | input | 8 | Byte to send for data and instruction requests |
| req_line | input | 1 | Cursor line (0 or 1) |
| req_col | input | 4 | Cursor column (0 to 15) |
| lcd_e | output | 1 | Display enable strobe |
| lcd_rs | output | 1 | Register select: 0 instruction, 1 data |
| lcd_rw | output | 1 | Read/write select, held at write (0) |
| lcd_db | output | 4 | Data nibble (DB7..DB4) |
| lcd_drive | output | 1 | Bus ownership enable for the shared pins |

## Verification
On every cycle the embedded assertions check the pin-level rules. The enable only rises with drive high, and a released bus sits at zero. Ready is never offered while the pins are driven. RS and the nibble do not move on the edge where the enable rises, nor while it stays high. The bench scenarios cover what needs a view of whole sequences. They check the order and values of the power-up nibbles and bytes, and the length of every gap against its minimum in time units. They also check the cursor address encoding for both lines, the long wait after a clear, and that unused request fields have no effect on what goes out.

// File: rtl/lcd_nibble_ctrl.sv
module lcd_nibble_ctrl #(
  parameter int unsigned CLK_HZ = 50_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [1:0] req_kind,
  input  logic [7:0] req_byte,
  input  logic       req_line,
  input  logic [3:0] req_col,
  output logic       lcd_e,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic [3:0] lcd_db,
  output logic       lcd_drive
);

  // cycles strictly longer than the given time in ns
  function automatic longint unsigned over_ns(longint unsigned ns);
    return (ns * longint'(CLK_HZ)) / 64'd1_000_000_000 + 64'd1;
  endfunction

  localparam int unsigned N_PWR   = 32'(over_ns(15_000_000));
  localparam int unsigned N_I1    = 32'(over_ns(4_100_000));
  localparam int unsigned N_I2    = 32'(over_ns(100_000));
  localparam int unsigned N_SHORT = 32'(over_ns(40_000));
  localparam int unsigned N_CLR   = 32'(over_ns(1_640_000));
  localparam int unsigned N_NIB   = 32'(over_ns(1_000));
  localparam int unsigned N_SU    = 32'(over_ns(40));
  localparam int unsigned N_EH    = 32'(over_ns(230));
  localparam int          TW      = $clog2(N_PWR + 1);
  localparam int unsigned LAST_STEP = 8;

  typedef enum logic [1:0] {S_PWR, S_LOAD, S_XFER, S_IDLE} st_t;
  typedef enum logic [1:0] {P_SU, P_HI, P_GAP} ph_t;

  st_t           st;
  ph_t           ph;
  logic [3:0]    step;
  logic [TW-1:0] timer;
  logic [TW-1:0] xtail;
  logic [7:0]    xbyte;
  logic          xtwo, xlow;

  logic          start, ld_two, ld_rs;
  logic [7:0]    ld_byte;
  logic [TW-1:0] ld_tail;

  assign req_ready = (st == S_IDLE);
  assign lcd_rw    = 1'b0;
  assign start     = (st == S_LOAD) || (st == S_IDLE && req_valid);

  always_comb begin
    ld_two  = 1'b1;
    ld_rs   = 1'b0;
    ld_byte = 8'h00;
    ld_tail = TW'(N_SHORT - 1);
    if (st == S_IDLE) begin
      ld_byte = req_kind[1] ? {1'b1, req_line, 2'b00, req_col} : req_byte;
      ld_rs   = ~req_kind[1] & req_kind[0];
      if (!ld_rs && ld_byte == 8'h01) ld_tail = TW'(N_CLR - 1);
    end else begin
      case (step[2:0])
        3'd0: begin ld_two = 1'b0; ld_byte = 8'h30; ld_tail = TW'(N_I1 - 1); end
        3'd1: begin ld_two = 1'b0; ld_byte = 8'h30; ld_tail = TW'(N_I2 - 1); end
        3'd2: begin ld_two = 1'b0; ld_byte = 8'h30; end
        3'd3: begin ld_two = 1'b0; ld_byte = 8'h20; end
        3'd4: ld_byte = 8'h28;
        3'd5: ld_byte = 8'h06;
        3'd6: ld_byte = 8'h0C;
        default: begin ld_byte = 8'h01; ld_tail = TW'(N_CLR - 1); end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_PWR;
      ph        <= P_SU;
      step      <= '0;
      timer     <= TW'(N_PWR - 1);
      xtail     <= '0;
      xbyte     <= '0;
      xtwo      <= 1'b0;
      xlow      <= 1'b0;
      lcd_e     <= 1'b0;
      lcd_rs    <= 1'b0;
      lcd_db    <= '0;
      lcd_drive <= 1'b0;
    end else if (start) begin
      st        <= S_XFER;
      ph        <= P_SU;
      timer     <= TW'(N_SU - 1);
      xbyte     <= ld_byte;
      xtwo      <= ld_two;
      xtail     <= ld_tail;
      xlow      <= 1'b0;
      lcd_rs    <= ld_rs;
      lcd_db    <= ld_byte[7:4];
      lcd_drive <= 1'b1;
      if (st == S_LOAD) step <= step + 4'd1;
    end else if (st == S_PWR) begin
      if (timer == '0) st <= S_LOAD;
      else timer <= timer - 1'b1;
    end else if (st == S_XFER) begin
      if (timer != '0) begin
        timer <= timer - 1'b1;
      end else begin
        case (ph)
          P_SU: begin
            lcd_e <= 1'b1;
            ph    <= P_HI;
            timer <= TW'(N_EH - 1);
          end
          P_HI: begin
            lcd_e <= 1'b0;
            ph    <= P_GAP;
            timer <= (xtwo && !xlow) ? TW'(N_NIB - 1) : xtail;
          end
          default: begin
            if (xtwo && !xlow) begin
              xlow   <= 1'b1;
              lcd_db <= xbyte[3:0];
              ph     <= P_SU;
              timer  <= TW'(N_SU - 1);
            end else begin
              lcd_drive <= 1'b0;
              lcd_db    <= '0;
              lcd_rs    <= 1'b0;
              st        <= (step == 4'(LAST_STEP)) ? S_IDLE : S_LOAD;
            end
          end
        endcase
      end
    end
  end

  AST_STROBE_OWNS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_e |-> lcd_drive); // R10
  AST_RELEASED_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_drive |-> (lcd_db == 4'h0 && !lcd_rs && !lcd_e)); // R10
  AST_NO_READY_WHILE_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_drive |-> !req_ready); // R11
  AST_SETUP_BEFORE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_e) |-> $stable({lcd_rs, lcd_db})); // R7
  AST_HOLD_DURING_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_e && $past(lcd_e)) |-> $stable({lcd_rs, lcd_db})); // R7

endmodule

// File: tb/test_lcd_nibble_ctrl.sv
module test_lcd_nibble_ctrl;
  localparam int unsigned HZ = 1_000_000;
  localparam longint NS_CYC = 1_000_000_000 / HZ;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_kind = 2'b00;
  logic [7:0] req_byte = 8'h00;
  logic       req_line = 1'b0;
  logic [3:0] req_col = 4'h0;
  logic       lcd_e, lcd_rs, lcd_rw, lcd_drive;
  logic [3:0] lcd_db;

  lcd_nibble_ctrl #(.CLK_HZ(HZ)) i_lcd_nibble_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_byte(req_byte), .req_line(req_line), .req_col(req_col),
    .lcd_e(lcd_e), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_db(lcd_db), .lcd_drive(lcd_drive)
  );

  always #2 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  longint ev_rise [64];
  longint ev_fall [64];
  longint ev_su   [64];
  logic [3:0] ev_nib [64];
  logic ev_rs [64];
  logic ev_rw [64];
  logic ev_drv [64];
  int ev_n = 0;
  logic prev_e = 1'b0;
  logic [5:0] prev_bus = '0;
  longint last_chg = 0;

  always @(negedge clk) begin
    if ({lcd_rs, lcd_rw, lcd_db} != prev_bus) last_chg = cyc;
    if (lcd_e && !prev_e && ev_n < 64) begin
      ev_rise[ev_n] = cyc;
      ev_su[ev_n]   = cyc - last_chg;
      ev_nib[ev_n]  = lcd_db;
      ev_rs[ev_n]   = lcd_rs;
      ev_rw[ev_n]   = lcd_rw;
      ev_drv[ev_n]  = lcd_drive;
      ev_n++;
    end
    if (!lcd_e && prev_e && ev_n > 0) ev_fall[ev_n-1] = cyc;
    prev_e   = lcd_e;
    prev_bus = {lcd_rs, lcd_rw, lcd_db};
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_over(longint cycles, longint ns, string req, string what);
    chk(cycles * NS_CYC > ns, req, {what, " (ns, min exclusive)"}, cycles * NS_CYC, ns);
  endtask

  task automatic chk_pulse(int i, logic [3:0] nib, logic rs, string req);
    chk(ev_nib[i] == nib, req, $sformatf("nibble %0d value", i), ev_nib[i], nib);
    chk(ev_rs[i] == rs, "R6", $sformatf("nibble %0d rs", i), ev_rs[i], rs);
    chk(ev_rw[i] == 1'b0, "R6", $sformatf("nibble %0d rw", i), ev_rw[i], 0);
    chk(ev_drv[i] == 1'b1, "R10", $sformatf("nibble %0d drive", i), ev_drv[i], 1);
    chk(ev_su[i] * NS_CYC >= 40, "R7", $sformatf("nibble %0d setup ns", i), ev_su[i] * NS_CYC, 40);
    chk_over(ev_fall[i] - ev_rise[i], 230, "R7", $sformatf("nibble %0d enable width", i));
  endtask

  task automatic wait_ready(output longint when);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    when = cyc;
  endtask

  task automatic check_idle_bus(string tag);
    chk(lcd_drive == 1'b0, "R10", {tag, " drive released"}, lcd_drive, 0);
    chk(lcd_db == 4'h0 && !lcd_rs && !lcd_e, "R10", {tag, " bus parked"}, {lcd_e, lcd_rs, lcd_db}, 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(lcd_e == 0 && lcd_rs == 0 && lcd_rw == 0, "R1", "control pins in reset", {lcd_e, lcd_rs, lcd_rw}, 0);
    chk(lcd_drive == 0 && lcd_db == 0, "R1", "drive and data in reset", {lcd_drive, lcd_db}, 0);
    chk(req_ready == 0, "R1", "ready in reset", req_ready, 0);
  endtask

  task automatic t_powerup;
    longint rel, rdy;
    logic [3:0] exp_n [12] = '{4'h3, 4'h3, 4'h3, 4'h2, 4'h2, 4'h8, 4'h0, 4'h6, 4'h0, 4'hC, 4'h0, 4'h1};
    longint gap_ns [11] = '{4_100_000, 100_000, 40_000, 40_000,
                            1_000, 40_000, 1_000, 40_000, 1_000, 40_000, 1_000};
    @(negedge clk);
    rst_n = 1'b1;
    rel = cyc;
    @(negedge clk);
    chk(req_ready == 0, "R11", "ready low during power-up", req_ready, 0);
    wait_ready(rdy);
    chk(ev_n == 12, "R4", "power-up strobe count", ev_n, 12);
    if (ev_n == 12) begin
      chk_over(ev_rise[0] - rel, 15_000_000, "R2", "power-on wait");
      for (int i = 0; i < 12; i++) chk_pulse(i, exp_n[i], 1'b0, i < 4 ? "R3" : "R4");
      for (int i = 0; i < 11; i++)
        chk_over(ev_rise[i+1] - ev_fall[i], gap_ns[i], i < 4 ? "R3" : "R5",
                 $sformatf("gap after nibble %0d", i));
      chk_over(rdy - ev_fall[11], 1_640_000, "R9", "clear wait at power-up");
    end
    check_idle_bus("after power-up");
  endtask

  task automatic send(logic [1:0] kind, logic [7:0] b, logic ln, logic [3:0] col,
                      logic [7:0] exp_b, logic exp_rs, longint tail_ns, string req, string tag);
    longint rdy;
    int base;
    wait_ready(rdy);
    base = ev_n;
    req_kind = kind; req_byte = b; req_line = ln; req_col = col;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 0, "R11", {tag, " ready drops on accept"}, req_ready, 0);
    chk(lcd_drive == 1, "R10", {tag, " drive on transfer start"}, lcd_drive, 1);
    wait_ready(rdy);
    chk(ev_n - base == 2, "R5", {tag, " strobe count"}, ev_n - base, 2);
    if (ev_n - base == 2) begin
      chk_pulse(base, exp_b[7:4], exp_rs, req);
      chk_pulse(base + 1, exp_b[3:0], exp_rs, req);
      chk_over(ev_rise[base+1] - ev_fall[base], 1_000, "R5", {tag, " nibble gap"});
      chk_over(rdy - ev_fall[base+1], tail_ns, tail_ns > 40_000 ? "R9" : "R5", {tag, " trailing wait"});
    end
    check_idle_bus(tag);
  endtask

  // R6, R11: data kind, cursor fields ignored
  task automatic t_data;
    send(2'b01, 8'h4A, 1'b1, 4'h9, 8'h4A, 1'b1, 40_000, "R6", "data 0x4A");
  endtask

  // R6, R11: instruction kind
  task automatic t_instr;
    send(2'b00, 8'h0E, 1'b1, 4'h3, 8'h0E, 1'b0, 40_000, "R6", "instruction 0x0E");
  endtask

  // R8, R11: cursor, byte field ignored
  task automatic t_cursor_line0;
    send(2'b10, 8'hFF, 1'b0, 4'h5, 8'h85, 1'b0, 40_000, "R8", "cursor line0 col5");
  endtask

  task automatic t_cursor_line1;
    send(2'b11, 8'h01, 1'b1, 4'hF, 8'hCF, 1'b0, 40_000, "R8", "cursor line1 col15");
  endtask

  task automatic t_cursor_origin;
    send(2'b10, 8'h55, 1'b0, 4'h0, 8'h80, 1'b0, 40_000, "R8", "cursor line0 col0");
  endtask

  // R9: clear on request
  task automatic t_clear;
    send(2'b00, 8'h01, 1'b0, 4'h0, 8'h01, 1'b0, 1_640_000, "R9", "clear");
  endtask

  // R9: byte 0x01 as data is not a clear
  task automatic t_data_one;
    send(2'b01, 8'h01, 1'b0, 4'h0, 8'h01, 1'b1, 40_000, "R6", "data 0x01");
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    summary();
  end

  initial begin
    t_reset();
    t_powerup();
    t_data();
    t_instr();
    t_cursor_line0();
    t_cursor_line1();
    t_cursor_origin();
    t_clear();
    t_data_one();
    repeat (5) @(negedge clk);
    summary();
  end
endmodule